// File: doc/BRIEF.md
# Programmable Watchdog Timer

The block is a watchdog that counts down in sixteenths of a second. Its timeout is set by an 8-bit control register holding a 5-bit multiplier and a 2-bit resolution code. The loaded interval is the multiplier times 1, 4, 16 or 64, depending on the code. The countdown advances only on cycles where a 16 Hz tick enable is high. A steering bit in the same register decides what happens at expiry: the block either pulses an interrupt or requests a system reset. In both cases it sets a sticky expiry flag.

Software keeps the watchdog alive in two ways. It can rewrite the control register, or it can read the flags register. Either access reloads the countdown and clears the flag. The flags register is read-only. An auxiliary byte register sits beside the control register. On the reset path the control register is cleared to zero and one bit of the auxiliary register is dropped. This marks that the reset came from the watchdog.

The bus is a simple single-cycle select/write port with combinational read data. Generating the tick from the system clock and sequencing the CPU reset are left to the surrounding logic.

Top module: `wdog_timer`

## Requirements
- R1: After reset the flags, control and auxiliary registers all read 0x00, and neither irq_o nor sys_rst_req_o is high.
- R2: The address map is 0 = flags, 1 = control, 2 = auxiliary; address 3 reads 0x00. In the control register, bits 6:2 are the multiplier M and bits 1:0 are the resolution code K. Expiry happens on exactly the (M << 2K)-th high tick16_i after a reload, never earlier. Cycles without a tick do not advance the count.
- R3: A write to the control register clears the flags bit 7 and restarts the countdown from the written value.
- R4: At expiry, bit 7 of the flags register becomes 1; the other flag bits always read 0.
- R5: If control bit 7 is 1 at expiry, sys_rst_req_o is high for exactly one cycle and irq_o stays low. In the same step the control register becomes 0x00 and bit 6 of the auxiliary register becomes 0, with the other auxiliary bits kept.
- R6: If control bit 7 is 0 at expiry, irq_o is high for exactly one cycle, sys_rst_req_o stays low, and the control register keeps its value.
- R7: A read of the flags register returns the flag as it stood, then clears it and reloads the countdown from the current control value.
- R8: Writes to the flags register change neither the flag nor the running countdown.
- R9: A multiplier of zero disables the watchdog: no expiry occurs, however many ticks arrive.
- R10: After an expiry the countdown stops, and no further pulse occurs until the next reload.
- R11: A reload (control write or flags read) in the same cycle as the expiring tick wins. No pulse is produced, the flag stays clear, and the countdown restarts in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | 16 Hz count enable, one cycle high per tick |
| sel_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while a read is selected |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| sys_rst_req_o | output | 1 | One-cycle system reset request on expiry |

## Verification
Two functions can coincide in one cycle: a software restart (a control write or a flags read) and the final tick that would make the count expire. The bench arms a one-tick interval and then raises the tick together with the restarting access in the same cycle. It does this for both the interrupt and the reset path. It judges the outcome as follows. No pulse may appear in the following cycle. A flags read in that collision must return zero. The new interval must then run its full length before the pulse arrives, and the control register must keep the written value rather than be cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 2;
  localparam int MULT_W      = 5;
  localparam int RES_W       = 2;
  localparam int MULT_LSB    = RES_W;
  localparam int STEER_BIT   = 7;
  localparam int FLAG_BIT    = 7;
  localparam int AUX_CLR_BIT = 6;
  localparam int MAX_SHIFT   = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W       = MULT_W + MAX_SHIFT;

  typedef enum logic [ADDR_W-1:0] {
    WD_ADR_FLAGS = 2'd0,
    WD_ADR_CTRL  = 2'd1,
    WD_ADR_AUX   = 2'd2,
    WD_ADR_SPARE = 2'd3
  } wd_addr_e;

  function automatic logic [CNT_W-1:0] interval_of(input logic [DATA_W-1:0] ctrl);
    logic [CNT_W-1:0] mult;
    mult = CNT_W'(ctrl[MULT_LSB +: MULT_W]);
    return mult << (2 * ctrl[RES_W-1:0]);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          expire_i,
  output logic [DW-1:0] rdata_o,
  output logic          reload_o,
  output logic [DW-1:0] reload_val_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] aux_o,
  output logic          flag_o
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] aux_q, aux_d;
  logic          flag_q, flag_d;
  logic          ctrl_wr, aux_wr, flag_rd, rst_path;
  wd_addr_e      adr;

  assign adr      = wd_addr_e'(addr_i);
  assign ctrl_wr  = sel_i && wr_i && (adr == WD_ADR_CTRL);
  assign aux_wr   = sel_i && wr_i && (adr == WD_ADR_AUX);
  assign flag_rd  = sel_i && !wr_i && (adr == WD_ADR_FLAGS);
  assign rst_path = expire_i && ctrl_q[STEER_BIT];

  assign reload_o     = ctrl_wr || flag_rd;
  assign reload_val_o = ctrl_wr ? wdata_i : ctrl_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)       ctrl_d = wdata_i;
    else if (rst_path) ctrl_d = '0;

    aux_d = aux_q;
    if (aux_wr)   aux_d = wdata_i;
    if (rst_path) aux_d[AUX_CLR_BIT] = 1'b0;

    flag_d = flag_q;
    if (reload_o)      flag_d = 1'b0;
    else if (expire_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aux_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr || rst_path) ctrl_q <= ctrl_d;
      if (aux_wr || rst_path)  aux_q  <= aux_d;
      if (reload_o || expire_i) flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !wr_i) begin
      unique case (adr)
        WD_ADR_FLAGS: rdata_o[FLAG_BIT] = flag_q;
        WD_ADR_CTRL:  rdata_o = ctrl_q;
        WD_ADR_AUX:   rdata_o = aux_q;
        default:      rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign aux_o  = aux_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic [DW-1:0] reload_val_i,
  output logic          expire_o,
  output logic          armed_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic [CW-1:0] load_val;
  logic          step;

  assign load_val = interval_of(reload_val_i);
  assign step     = armed_q && tick_i;
  assign expire_o = step && (cnt_q == CW'(1)) && !reload_i;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (reload_i) begin
      cnt_d   = load_val;
      armed_d = (load_val != '0);
    end else if (step) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (reload_i || step) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdog_action.sv
module wdog_action (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic steer_rst_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, irq_d, req_q, req_d;

  always_comb begin
    irq_d = expire_i && !steer_rst_i;
    req_d = expire_i && steer_rst_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      req_q <= req_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sys_rst_req_o
);
  logic          reload;
  logic [DW-1:0] reload_val;
  logic          expire;
  logic          armed;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] aux_q;
  logic          flag_q;

  wdog_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (sel_i),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .expire_i     (expire),
    .rdata_o      (rdata_o),
    .reload_o     (reload),
    .reload_val_o (reload_val),
    .ctrl_o       (ctrl_q),
    .aux_o        (aux_q),
    .flag_o       (flag_q)
  );

  wdog_countdown #(.DW(DW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick16_i),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .expire_o     (expire),
    .armed_o      (armed)
  );

  wdog_action u_act (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire_i    (expire),
    .steer_rst_i (ctrl_q[STEER_BIT]),
    .irq_o       (irq_o),
    .rst_req_o   (sys_rst_req_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16_i,
  input logic       sel_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic       irq_o,
  input logic       sys_rst_req_o,
  input logic [7:0] ctrl_q,
  input logic [7:0] aux_q,
  input logic       flag_q,
  input logic       armed
);
  p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_one_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && sys_rst_req_o));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || sys_rst_req_o) |-> flag_q);

  p_ctrl_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |-> (ctrl_q == 8'h00 && !aux_q[6]));

  p_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && addr_i == 2'd1) |=> !flag_q);

  p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !wr_i && addr_i == 2'd0) |=> !flag_q);

  p_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !(irq_o || sys_rst_req_o));

  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick16_i |=> !(irq_o || sys_rst_req_o));
endmodule

bind wdog_timer wdog_timer_chk i_wdog_timer_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick16_i      (tick16_i),
  .sel_i         (sel_i),
  .wr_i          (wr_i),
  .addr_i        (addr_i),
  .irq_o         (irq_o),
  .sys_rst_req_o (sys_rst_req_o),
  .ctrl_q        (ctrl_q),
  .aux_q         (aux_q),
  .flag_q        (flag_q),
  .armed         (armed)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic       rstreq;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick16_i      (tick),
    .sel_i         (sel),
    .wr_i          (wr),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .rdata_o       (rdata),
    .irq_o         (irq),
    .sys_rst_req_o (rstreq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic ticks(input int n, output int ni, output int nr, output int nw);
    ni = 0; nr = 0; nw = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      #1 if (irq) ni++;
      if (rstreq) nr++;
      @(negedge clk);
      #1 if (irq || rstreq) nw++;
    end
  endtask

  // tick and a bus access in the same cycle
  task automatic tick_bus(input logic w, input logic [1:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int pulses);
    @(negedge clk); tick = 1'b1; sel = 1'b1; wr = w; addr = a; wdata = d;
    #1 rd = rdata;
    @(negedge clk); tick = 1'b0; sel = 1'b0; wr = 1'b0;
    #1 pulses = int'(irq) + int'(rstreq);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq", irq, 0);
    chk("R1 rstreq", rstreq, 0);
    bus_rd(2'd0, d); chk("R1 flags", d, 8'h00);
    bus_rd(2'd1, d); chk("R1 ctrl", d, 8'h00);
    bus_rd(2'd2, d); chk("R1 aux", d, 8'h00);
    bus_rd(2'd3, d); chk("R2 spare addr", d, 8'h00);
  endtask

  task automatic t_irq_path();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd1, 8'h0D);               // M=3 K=1 -> 12 ticks
    ticks(11, ni, nr, nw);
    chk("R2 early irq", ni + nr, 0);
    ticks(1, ni, nr, nw);
    chk("R6 irq at 12", ni, 1);
    chk("R6 no rstreq", nr, 0);
    chk("R6 width", nw, 0);
    bus_rd(2'd1, d); chk("R6 ctrl kept", d, 8'h0D);
    bus_rd(2'd0, d); chk("R4 flag set", d, 8'h80);
    bus_rd(2'd0, d); chk("R7 flag cleared by read", d, 8'h00);
  endtask

  task automatic t_read_reload();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd1, 8'h0D);
    ticks(10, ni, nr, nw);
    bus_rd(2'd0, d);
    ticks(11, ni, nr, nw);
    chk("R7 reload delays expiry", ni + nr, 0);
    ticks(1, ni, nr, nw);
    chk("R7 expiry after reload", ni, 1);
    ticks(40, ni, nr, nw);
    chk("R10 stopped after expiry", ni + nr, 0);
    repeat (20) @(negedge clk);
    #1 chk("R2 no tick no pulse", int'(irq) + int'(rstreq), 0);
  endtask

  task automatic t_reset_path();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd1, 8'h84);               // steer=1 M=1 K=0
    ticks(1, ni, nr, nw);
    chk("R5 rstreq", nr, 1);
    chk("R5 no irq", ni, 0);
    chk("R5 width", nw, 0);
    bus_rd(2'd1, d); chk("R5 ctrl cleared", d, 8'h00);
    bus_rd(2'd2, d); chk("R5 aux bit6 cleared", d, 8'hBF);
    bus_rd(2'd0, d); chk("R4 flag set on reset path", d, 8'h80);
    ticks(5, ni, nr, nw);
    chk("R10 no pulse after reset path", ni + nr, 0);
  endtask

  task automatic t_write_restart();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd1, 8'h04);
    ticks(1, ni, nr, nw);
    bus_wr(2'd1, 8'h05);               // 4 ticks
    ticks(3, ni, nr, nw);
    chk("R3 restart early", ni + nr, 0);
    ticks(1, ni, nr, nw);
    chk("R3 restart expiry", ni, 1);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd0, d); chk("R3 write clears flag", d, 8'h00);
  endtask

  task automatic t_flags_ro();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd1, 8'h04);
    ticks(1, ni, nr, nw);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, d); chk("R8 write cannot clear flag", d, 8'h80);
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, d); chk("R8 write cannot set flag", d, 8'h00);
    bus_wr(2'd1, 8'h08);               // 2 ticks
    ticks(1, ni, nr, nw);
    bus_wr(2'd0, 8'h00);
    ticks(1, ni, nr, nw);
    chk("R8 write does not reload", ni, 1);
  endtask

  task automatic t_disabled();
    logic [7:0] d; int ni, nr, nw;
    bus_wr(2'd1, 8'h03);
    ticks(100, ni, nr, nw);
    chk("R9 disabled irq path", ni + nr, 0);
    bus_wr(2'd1, 8'h80);
    ticks(10, ni, nr, nw);
    chk("R9 disabled reset path", ni + nr, 0);
    bus_rd(2'd1, d); chk("R9 ctrl untouched", d, 8'h80);
  endtask

  task automatic t_collision();
    logic [7:0] d; int ni, nr, nw, p;
    bus_wr(2'd1, 8'h04);
    tick_bus(1'b1, 2'd1, 8'h08, d, p);
    chk("R11 write beats expiry", p, 0);
    ticks(1, ni, nr, nw);
    chk("R11 full restart", ni + nr, 0);
    ticks(1, ni, nr, nw);
    chk("R11 expiry after restart", ni, 1);
    bus_wr(2'd1, 8'h04);
    tick_bus(1'b0, 2'd0, 8'h00, d, p);
    chk("R11 read beats expiry", p, 0);
    chk("R11 read value", d, 8'h00);
    ticks(1, ni, nr, nw);
    chk("R11 expiry after read reload", ni, 1);
    bus_wr(2'd1, 8'h84);
    tick_bus(1'b1, 2'd1, 8'h84, d, p);
    chk("R11 reset path suppressed", p, 0);
    bus_rd(2'd1, d); chk("R11 ctrl not cleared", d, 8'h84);
    bus_wr(2'd1, 8'h00);
  endtask

  task automatic t_resolutions();
    int ni, nr, nw, len;
    for (int k = 0; k < 4; k++) begin
      len = 2 << (2 * k);
      bus_wr(2'd1, 8'(8'h08 | k));
      ticks(len - 1, ni, nr, nw);
      chk("R2 resolution early", ni + nr, 0);
      ticks(1, ni, nr, nw);
      chk("R2 resolution expiry", ni, 1);
    end
    bus_wr(2'd1, 8'h7F);               // 31*64 = 1984 ticks
    ticks(1983, ni, nr, nw);
    chk("R2 max early", ni + nr, 0);
    ticks(1, ni, nr, nw);
    chk("R2 max expiry", ni, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq_path();
    t_read_reload();
    t_reset_path();
    t_write_restart();
    t_flags_ro();
    t_disabled();
    t_collision();
    t_resolutions();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule